// File: doc/BRIEF.md
# Keyboard Controller Host Command Front End

This block is the processor-facing side of a PC-style keyboard controller. The host writes bytes either to a command port or to a data port, selected per access, and reads a live status byte. Command bytes are decoded at once. Most of them act immediately: they change the mode byte, move the A20 gate, pulse the system reset line, or queue a reply byte toward the keyboard receive queue. A small group of commands arms a pending state instead. The next data-port write is then steered by that pending command, and the pending state clears.

Reply and forwarded bytes leave through four one-cycle push strobes, each with its own data byte:
- keyboard queue
- auxiliary queue
- keyboard device
- mouse device

The queues and serial devices sit outside this block. They report back through two pending levels. From those levels and the mode byte, the block forms the status flags and two interrupt requests. The width of the reset pulse is a parameter counted in clock cycles.

Top module: `kbc_front`

## Requirements
- R1: After reset, `mode_o` is 0x03, `status_o` is 0x18 when neither pending input is set, `outport_o` is 0x03, `a20_o` is 1 and `sys_rst_no` is 1.
- R2: Command codes 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 arm a pending state. The next data-port write acts as follows, and the pending state then clears:
  - 0x60: loads `mode_o`.
  - 0xD1: loads the output port byte.
  - 0xD2: pushes the byte to the keyboard queue.
  - 0xD3: pushes the byte to the auxiliary queue.
  - 0xD4: forwards the byte to the mouse device.
- R3: A data-port write with no pending command is forwarded unchanged to the keyboard device.
- R4: Command 0x20 pushes the mode byte to the keyboard queue. Command 0xD0 pushes the output port byte as seen on `outport_o`, in which bit 4 is the any-pending flag and bit 5 is the auxiliary-only flag.
- R5: Command 0xAA sets status bit 2 and pushes 0x55. Commands 0xA9 and 0xAB push 0x00. Command 0xC0 pushes 0x80. All of these go to the keyboard queue.
- R6: Commands 0xA7 and 0xA8 set and clear mode bit 5. Commands 0xAD and 0xAE set and clear mode bit 4.
- R7: Command 0xDF sets output port bit 1 and `a20_o`. Command 0xDD clears both.
- R8: Any command 0xF0 to 0xFF with bit 0 clear starts a reset pulse. The same range with bit 0 set has no effect.
- R9: An output-port load drives `a20_o` from data bit 1, and starts a reset pulse when data bit 0 is 0. `xlat_o` follows mode bit 6.
- R10: `sys_rst_no` goes low in the cycle after the triggering write and stays low for exactly RST_CYC cycles.
- R11: Any command code not listed in R2, R4 to R8 leaves mode, output port, status and pending state unchanged, and pushes nothing.
- R12: The status and interrupt outputs are formed as follows:
  - Status bit 0 is set when either pending input is high.
  - Status bit 5 is set when only the auxiliary pending input is high.
  - `irq_kbd_o` is keyboard-pending AND mode bit 0 AND NOT mode bit 4.
  - `irq_aux_o` is auxiliary-only AND mode bit 1.
- R13: Each push or forward strobe is high for exactly the one cycle after the write, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Single-cycle host write strobe |
| cmd_i | input | 1 | 1 selects the command port, 0 selects the data port |
| wdata_i | input | 8 | Host write byte |
| kbd_pend_i | input | 1 | Keyboard queue holds data |
| aux_pend_i | input | 1 | Auxiliary queue holds data |
| status_o | output | 8 | Status byte |
| mode_o | output | 8 | Mode byte |
| outport_o | output | 8 | Output port byte with live buffer flags |
| a20_o | output | 1 | A20 gate |
| sys_rst_no | output | 1 | System reset pulse, active low |
| xlat_o | output | 1 | Scan-code translation enable |
| irq_kbd_o | output | 1 | Keyboard interrupt request |
| irq_aux_o | output | 1 | Auxiliary interrupt request |
| kq_push_o | output | 1 | Push strobe to keyboard queue |
| kq_data_o | output | 8 | Byte for keyboard queue |
| aq_push_o | output | 1 | Push strobe to auxiliary queue |
| aq_data_o | output | 8 | Byte for auxiliary queue |
| kdev_wr_o | output | 1 | Forward strobe to keyboard device |
| kdev_data_o | output | 8 | Byte for keyboard device |
| mdev_wr_o | output | 1 | Forward strobe to mouse device |
| mdev_data_o | output | 8 | Byte for mouse device |

## Verification
A write of 0xAD, or of a new mode byte, can land in the same clock edge as a change on the pending inputs. The interrupt outputs must then reflect both the new mode and the new pending level together. The bench provokes this by raising the keyboard pending input in the very cycle that carries the disable command. It then expects no keyboard interrupt afterward, and expects the interrupt to appear once 0xAE follows. All 256 command codes are swept from reset, each followed by two data writes, so every routing and every "no effect" case is judged against values the bench computes.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam logic [7:0] C_RD_MODE  = 8'h20;
  localparam logic [7:0] C_WR_MODE  = 8'h60;
  localparam logic [7:0] C_AUX_OFF  = 8'hA7;
  localparam logic [7:0] C_AUX_ON   = 8'hA8;
  localparam logic [7:0] C_AUX_TST  = 8'hA9;
  localparam logic [7:0] C_SELFTST  = 8'hAA;
  localparam logic [7:0] C_KBD_TST  = 8'hAB;
  localparam logic [7:0] C_KBD_OFF  = 8'hAD;
  localparam logic [7:0] C_KBD_ON   = 8'hAE;
  localparam logic [7:0] C_RD_IN    = 8'hC0;
  localparam logic [7:0] C_RD_OUT   = 8'hD0;
  localparam logic [7:0] C_WR_OUT   = 8'hD1;
  localparam logic [7:0] C_WR_KOB   = 8'hD2;
  localparam logic [7:0] C_WR_AOB   = 8'hD3;
  localparam logic [7:0] C_WR_AUX   = 8'hD4;
  localparam logic [7:0] C_A20_OFF  = 8'hDD;
  localparam logic [7:0] C_A20_ON   = 8'hDF;

  localparam int MB_KIRQ = 0;
  localparam int MB_AIRQ = 1;
  localparam int MB_KDIS = 4;
  localparam int MB_ADIS = 5;
  localparam int MB_XLAT = 6;
  localparam int OB_RST  = 0;
  localparam int OB_A20  = 1;

  localparam logic [7:0] MODE_RST = 8'h03;
  localparam logic [7:0] OUTP_RST = 8'h03;

  typedef enum logic [1:0] {Q_NONE, Q_CONST, Q_MODE, Q_OUTP} qsrc_e;

  typedef struct packed {
    logic       known;
    logic       arm;
    qsrc_e      qsrc;
    logic [7:0] qconst;
    logic       adis_set;
    logic       adis_clr;
    logic       kdis_set;
    logic       kdis_clr;
    logic       a20_set;
    logic       a20_clr;
    logic       selftest;
    logic       rst_req;
  } act_t;
endpackage

// File: rtl/kbc_cmd_dec.sv
module kbc_cmd_dec
  import kbc_pkg::*;
(
  input  logic [7:0] cmd_i,
  output act_t       act_o
);
  always_comb begin
    act_o = '0;
    if (cmd_i[7:4] == 4'hF) begin
      // pulse group: only bit 0 of the mask matters
      act_o.known   = 1'b1;
      act_o.rst_req = ~cmd_i[0];
    end else begin
      act_o.known = 1'b1;
      unique case (cmd_i)
        C_RD_MODE: act_o.qsrc = Q_MODE;
        C_RD_OUT:  act_o.qsrc = Q_OUTP;
        C_WR_MODE, C_WR_OUT, C_WR_KOB, C_WR_AOB, C_WR_AUX: act_o.arm = 1'b1;
        C_AUX_OFF: act_o.adis_set = 1'b1;
        C_AUX_ON:  act_o.adis_clr = 1'b1;
        C_KBD_OFF: act_o.kdis_set = 1'b1;
        C_KBD_ON:  act_o.kdis_clr = 1'b1;
        C_AUX_TST, C_KBD_TST: begin
          act_o.qsrc   = Q_CONST;
          act_o.qconst = 8'h00;
        end
        C_SELFTST: begin
          act_o.qsrc     = Q_CONST;
          act_o.qconst   = 8'h55;
          act_o.selftest = 1'b1;
        end
        C_RD_IN: begin
          act_o.qsrc   = Q_CONST;
          act_o.qconst = 8'h80;
        end
        C_A20_ON:  act_o.a20_set = 1'b1;
        C_A20_OFF: act_o.a20_clr = 1'b1;
        default:   act_o.known = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/kbc_rst_pulse.sv
module kbc_rst_pulse #(
  parameter int RST_CYC = 1200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic rst_no
);
  localparam int CW = $clog2(RST_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (trig_i)          cnt_q <= CW'(RST_CYC);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign rst_no = (cnt_q == '0);

  // R10
  pulse_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> !rst_no);
  // R10
  pulse_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_no && cnt_q > CW'(1)) |=> !rst_no);
endmodule

// File: rtl/kbc_irq_stat.sv
module kbc_irq_stat
  import kbc_pkg::*;
(
  input  logic [7:0] mode_i,
  input  logic       selftest_i,
  input  logic       kbd_pend_i,
  input  logic       aux_pend_i,
  output logic       obf_o,
  output logic       aobf_o,
  output logic [7:0] status_o,
  output logic       irq_kbd_o,
  output logic       irq_aux_o
);
  // keyboard data wins over aux data
  assign obf_o     = kbd_pend_i | aux_pend_i;
  assign aobf_o    = aux_pend_i & ~kbd_pend_i;
  assign status_o  = {2'b00, aobf_o, 1'b1, 1'b1, selftest_i, 1'b0, obf_o};
  assign irq_kbd_o = kbd_pend_i & mode_i[MB_KIRQ] & ~mode_i[MB_KDIS];
  assign irq_aux_o = aobf_o & mode_i[MB_AIRQ];
endmodule

// File: rtl/kbc_front.sv
module kbc_front
  import kbc_pkg::*;
#(
  parameter int RST_CYC = 1200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       cmd_i,
  input  logic [7:0] wdata_i,
  input  logic       kbd_pend_i,
  input  logic       aux_pend_i,
  output logic [7:0] status_o,
  output logic [7:0] mode_o,
  output logic [7:0] outport_o,
  output logic       a20_o,
  output logic       sys_rst_no,
  output logic       xlat_o,
  output logic       irq_kbd_o,
  output logic       irq_aux_o,
  output logic       kq_push_o,
  output logic [7:0] kq_data_o,
  output logic       aq_push_o,
  output logic [7:0] aq_data_o,
  output logic       kdev_wr_o,
  output logic [7:0] kdev_data_o,
  output logic       mdev_wr_o,
  output logic [7:0] mdev_data_o
);
  act_t       act;
  logic [7:0] mode_q, outp_q, pend_q, outp_view, qbyte;
  logic       selftest_q, obf, aobf, cmd_wr, dat_wr, rst_trig;

  assign cmd_wr = wr_i & cmd_i;
  assign dat_wr = wr_i & ~cmd_i;

  kbc_cmd_dec u_dec (.cmd_i(wdata_i), .act_o(act));

  kbc_irq_stat u_irq (
    .mode_i(mode_q), .selftest_i(selftest_q),
    .kbd_pend_i(kbd_pend_i), .aux_pend_i(aux_pend_i),
    .obf_o(obf), .aobf_o(aobf), .status_o(status_o),
    .irq_kbd_o(irq_kbd_o), .irq_aux_o(irq_aux_o)
  );

  assign outp_view = {outp_q[7:6], aobf, obf, outp_q[3:0]};

  always_comb begin
    unique case (act.qsrc)
      Q_CONST: qbyte = act.qconst;
      Q_MODE:  qbyte = mode_q;
      Q_OUTP:  qbyte = outp_view;
      default: qbyte = 8'h00;
    endcase
  end

  assign rst_trig = (cmd_wr & act.rst_req) |
                    (dat_wr & (pend_q == C_WR_OUT) & ~wdata_i[OB_RST]);

  kbc_rst_pulse #(.RST_CYC(RST_CYC)) u_pulse (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(rst_trig), .rst_no(sys_rst_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= MODE_RST;
      outp_q      <= OUTP_RST;
      pend_q      <= '0;
      selftest_q  <= 1'b0;
      kq_push_o   <= 1'b0;
      aq_push_o   <= 1'b0;
      kdev_wr_o   <= 1'b0;
      mdev_wr_o   <= 1'b0;
      kq_data_o   <= '0;
      aq_data_o   <= '0;
      kdev_data_o <= '0;
      mdev_data_o <= '0;
    end else begin
      kq_push_o <= 1'b0;
      aq_push_o <= 1'b0;
      kdev_wr_o <= 1'b0;
      mdev_wr_o <= 1'b0;
      if (cmd_wr) begin
        if (act.arm)      pend_q <= wdata_i;
        if (act.adis_set) mode_q[MB_ADIS] <= 1'b1;
        if (act.adis_clr) mode_q[MB_ADIS] <= 1'b0;
        if (act.kdis_set) mode_q[MB_KDIS] <= 1'b1;
        if (act.kdis_clr) mode_q[MB_KDIS] <= 1'b0;
        if (act.a20_set)  outp_q[OB_A20]  <= 1'b1;
        if (act.a20_clr)  outp_q[OB_A20]  <= 1'b0;
        if (act.selftest) selftest_q      <= 1'b1;
        if (act.qsrc != Q_NONE) begin
          kq_push_o <= 1'b1;
          kq_data_o <= qbyte;
        end
      end else if (dat_wr) begin
        pend_q <= '0;
        unique case (pend_q)
          C_WR_MODE: mode_q <= wdata_i;
          C_WR_OUT:  outp_q <= wdata_i;
          C_WR_KOB: begin kq_push_o <= 1'b1; kq_data_o   <= wdata_i; end
          C_WR_AOB: begin aq_push_o <= 1'b1; aq_data_o   <= wdata_i; end
          C_WR_AUX: begin mdev_wr_o <= 1'b1; mdev_data_o <= wdata_i; end
          default:  begin kdev_wr_o <= 1'b1; kdev_data_o <= wdata_i; end
        endcase
      end
    end
  end

  assign mode_o    = mode_q;
  assign outport_o = outp_view;
  assign a20_o     = outp_q[OB_A20];
  assign xlat_o    = mode_q[MB_XLAT];

  // R2
  mode_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr && pend_q == C_WR_MODE) |=> mode_o == $past(wdata_i));
  // R2
  pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_wr |=> pend_q == 8'h00);
  // R7
  a20_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i == C_A20_ON) |=> a20_o);
  // R11
  unsup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !act.known) |=> ($stable(mode_q) && $stable(outp_q) &&
                                $stable(pend_q) && $stable(selftest_q) && !kq_push_o));
  // R13
  push_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({kq_push_o, aq_push_o, kdev_wr_o, mdev_wr_o}));
  // R3
  fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr && pend_q == 8'h00) |=> (kdev_wr_o && kdev_data_o == $past(wdata_i)));
endmodule

// File: tb/kbc_front_test.sv
`timescale 1ns/1ps
module kbc_front_test;
  localparam int RC = 8;

  logic clk = 1'b0, rst_ni = 1'b0, wr_i = 1'b0, cmd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic kbd_pend_i = 1'b0, aux_pend_i = 1'b0;
  logic [7:0] status_o, mode_o, outport_o, kq_data_o, aq_data_o, kdev_data_o, mdev_data_o;
  logic a20_o, sys_rst_no, xlat_o, irq_kbd_o, irq_aux_o, kq_push_o, aq_push_o, kdev_wr_o, mdev_wr_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  kbc_front #(.RST_CYC(RC)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .cmd_i(cmd_i), .wdata_i(wdata_i),
    .kbd_pend_i(kbd_pend_i), .aux_pend_i(aux_pend_i),
    .status_o(status_o), .mode_o(mode_o), .outport_o(outport_o), .a20_o(a20_o),
    .sys_rst_no(sys_rst_no), .xlat_o(xlat_o), .irq_kbd_o(irq_kbd_o), .irq_aux_o(irq_aux_o),
    .kq_push_o(kq_push_o), .kq_data_o(kq_data_o), .aq_push_o(aq_push_o), .aq_data_o(aq_data_o),
    .kdev_wr_o(kdev_wr_o), .kdev_data_o(kdev_data_o), .mdev_wr_o(mdev_wr_o), .mdev_data_o(mdev_data_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0; wr_i = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
  endtask

  // drive one strobe; returns at the negedge where registered results are visible
  task automatic strobe(input logic c, input logic [7:0] d);
    @(negedge clk); wr_i = 1'b1; cmd_i = c; wdata_i = d;
    @(negedge clk); wr_i = 1'b0;
  endtask

  function automatic logic [3:0] strobes();
    return {kq_push_o, aq_push_o, kdev_wr_o, mdev_wr_o};
  endfunction

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    finish_up();
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R1 mode", mode_o, 8'h03);
    chk("R1 status", status_o, 8'h18);
    chk("R1 outport", outport_o, 8'h03);
    chk("R1 a20/rst", {6'b0, a20_o, sys_rst_no}, 8'h03);

    // sweep every command code from reset, then two data writes
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cc, e_mode, e_out, e_stat, e_q;
      logic e_push, e_rst;
      cc = 8'(c);
      do_reset();
      strobe(1'b1, cc);
      e_push = 1'b1; e_mode = 8'h03; e_out = 8'h03; e_stat = 8'h18; e_q = 8'h00;
      case (cc)
        8'h20: e_q = 8'h03;
        8'hD0: e_q = 8'h03;
        8'hAA: begin e_q = 8'h55; e_stat = 8'h1C; end
        8'hA9, 8'hAB: e_q = 8'h00;
        8'hC0: e_q = 8'h80;
        default: e_push = 1'b0;
      endcase
      if (cc == 8'hA7) e_mode = 8'h23;
      if (cc == 8'hAD) e_mode = 8'h13;
      if (cc == 8'hDD) e_out = 8'h01;
      e_rst = (cc[7:4] == 4'hF) && !cc[0];
      // R4 R5 R11 queue push
      chk($sformatf("R5 push c=%h", cc), {4'b0, strobes()}, {4'b0, e_push, 3'b000});
      if (e_push) chk($sformatf("R4 qdata c=%h", cc), kq_data_o, e_q);
      // R6 R11
      chk($sformatf("R6 mode c=%h", cc), mode_o, e_mode);
      // R7 R11
      chk($sformatf("R7 outport c=%h", cc), outport_o, e_out);
      chk($sformatf("R7 a20 c=%h", cc), {7'b0, a20_o}, {7'b0, e_out[1]});
      chk($sformatf("R5 status c=%h", cc), status_o, e_stat);
      // R8
      chk($sformatf("R8 rst c=%h", cc), {7'b0, sys_rst_no}, {7'b0, !e_rst});
      // R13 strobe lasts one cycle
      @(negedge clk);
      chk($sformatf("R13 one cycle c=%h", cc), {4'b0, strobes()}, 8'h00);

      strobe(1'b0, 8'hC6);
      case (cc)
        8'h60: begin
          chk("R2 mode load", mode_o, 8'hC6);
          chk("R9 xlat", {7'b0, xlat_o}, 8'h01);
          chk("R2 no strobe", {4'b0, strobes()}, 8'h00);
        end
        8'hD1: begin
          chk("R2 outport load", outport_o, 8'hC6);
          chk("R9 a20 from data", {7'b0, a20_o}, 8'h01);
          chk("R9 reset from data", {7'b0, sys_rst_no}, 8'h00);
        end
        8'hD2: begin
          chk("R2 kq route", {4'b0, strobes()}, 8'h08);
          chk("R2 kq data", kq_data_o, 8'hC6);
        end
        8'hD3: begin
          chk("R2 aq route", {4'b0, strobes()}, 8'h04);
          chk("R2 aq data", aq_data_o, 8'hC6);
        end
        8'hD4: begin
          chk("R2 mouse route", {4'b0, strobes()}, 8'h01);
          chk("R2 mouse data", mdev_data_o, 8'hC6);
        end
        default: begin
          chk($sformatf("R3 route c=%h", cc), {4'b0, strobes()}, 8'h02);
          chk($sformatf("R3 data c=%h", cc), kdev_data_o, 8'hC6);
        end
      endcase
      // pending cleared: next data goes to keyboard device
      strobe(1'b0, 8'h11);
      chk($sformatf("R2 cleared c=%h", cc), {4'b0, strobes()}, 8'h02);
      chk($sformatf("R3 data2 c=%h", cc), kdev_data_o, 8'h11);
    end

    // R10 pulse width, command and output-port triggers
    for (int k = 0; k < 2; k++) begin
      int lows;
      do_reset();
      if (k == 0) strobe(1'b1, 8'hFE);
      else begin strobe(1'b1, 8'hD1); strobe(1'b0, 8'h02); end
      lows = 0;
      while (!sys_rst_no && lows < 50) begin lows++; @(negedge clk); end
      chk($sformatf("R10 width k=%0d", k), 8'(lows), 8'(RC));
    end

    // R12 status and interrupts over mode bits 0,1,4 and pending inputs
    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 4; p++) begin
        logic [7:0] mv;
        logic kp, ap, ek, ea, ob, aob;
        mv = {3'b0, m[2], 2'b00, m[1], m[0]};
        kp = p[0]; ap = p[1];
        do_reset();
        kbd_pend_i = kp; aux_pend_i = ap;
        strobe(1'b1, 8'h60);
        strobe(1'b0, mv);
        ob = kp | ap; aob = ap & !kp;
        ek = kp & mv[0] & !mv[4];
        ea = aob & mv[1];
        chk($sformatf("R12 status m=%0d p=%0d", m, p), status_o, {2'b0, aob, 2'b11, 2'b00, ob});
        chk($sformatf("R12 irq m=%0d p=%0d", m, p), {6'b0, irq_kbd_o, irq_aux_o}, {6'b0, ek, ea});
        chk($sformatf("R4 outport flags m=%0d p=%0d", m, p), outport_o, {2'b0, aob, ob, 4'h3});
        strobe(1'b1, 8'hD0);
        chk($sformatf("R4 D0 byte m=%0d p=%0d", m, p), kq_data_o, {2'b0, aob, ob, 4'h3});
      end
    end

    // pending input rises in the same cycle as the keyboard disable command
    do_reset();
    kbd_pend_i = 1'b0; aux_pend_i = 1'b0;
    @(negedge clk); wr_i = 1'b1; cmd_i = 1'b1; wdata_i = 8'hAD; kbd_pend_i = 1'b1;
    @(negedge clk); wr_i = 1'b0;
    chk("R12 irq masked same cycle", {7'b0, irq_kbd_o}, 8'h00);
    chk("R6 kdis set", mode_o, 8'h13);
    strobe(1'b1, 8'hAE);
    chk("R12 irq after enable", {7'b0, irq_kbd_o}, 8'h01);
    kbd_pend_i = 1'b0;

    finish_up();
  end
endmodule